// File: doc/BRIEF.md
# Fetch-to-Decode Instruction Window Queue

This block sits between an instruction fetch stage and a decode stage and lets the two run at different rates. In any cycle, fetch may offer one 32-byte instruction block that starts on a 32-byte boundary. An accepted block is split into two 16-byte windows. Each window is stored together with its own byte address. Decode always sees the two oldest windows at its outputs. It can take zero, one or two of them per cycle, and always in program order.

The queue holds 16 windows. Fetch is held off through a ready signal whenever fewer than two entries are free. A flush input, used on a branch redirect, throws away every stored window in a single cycle. The block only stores, orders and releases windows. It does not decode instruction lengths, predict branches or access any cache.

Top module: `ibq_top`

## Requirements
- R1: After reset, `occ_count` is 0, `is_empty` is 1, `is_full` is 0, `fill_ready` is 1, and both `win0_valid` and `win1_valid` are 0.
- R2: A block is accepted when `fill_valid`, `fill_ready` and not `flush` hold at a clock edge. It adds two entries. The lower entry has address `{fill_addr[31:5], 5'h00}` and data `fill_data[127:0]`. The upper entry has address `{fill_addr[31:5], 5'h10}` and data `fill_data[255:128]`. `fill_addr[4:0]` has no effect.
- R3: `fill_ready` is 1 exactly when at least two entries are free (`occ_count` <= 14). A block offered while `fill_ready` is 0 is not stored and leaves the contents unchanged.
- R4: `win0_*` shows the oldest stored window and `win1_*` shows the next oldest. `win0_valid` is 1 when `occ_count` >= 1. `win1_valid` is 1 when `occ_count` >= 2. The lower window of a block always leaves before its upper window.
- R5: `pop_req` encodes 0, 1 or 2 windows to remove from the head. The value 3 is treated as 2. A request larger than `occ_count` removes only the windows present.
- R6: When a write and pops occur in the same cycle, `occ_count` becomes old count + 2 − pops. The window order is still kept, including after an odd number of pops.
- R7: When `flush` is 1, the queue is empty after that clock edge. A write or pop presented in the same cycle has no effect.
- R8: `is_full` is 1 exactly when 16 windows are stored. `is_empty` is 1 exactly when none are stored.
- R9: `occ_count` always equals the number of windows stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all stored windows (redirect) |
| fill_valid | input | 1 | Fetch offers a block this cycle |
| fill_addr | input | 32 | Byte address of the offered block |
| fill_data | input | 256 | Block bytes; byte 0 in bits [7:0] |
| fill_ready | output | 1 | At least two entries free |
| pop_req | input | 2 | Windows taken by decode this cycle (0–2, 3 means 2) |
| win0_valid | output | 1 | Oldest window present |
| win0_addr | output | 32 | Byte address of oldest window |
| win0_data | output | 128 | Bytes of oldest window |
| win1_valid | output | 1 | Second oldest window present |
| win1_addr | output | 32 | Byte address of second oldest window |
| win1_data | output | 128 | Bytes of second oldest window |
| occ_count | output | 5 | Number of stored windows |
| is_full | output | 1 | Queue holds 16 windows |
| is_empty | output | 1 | Queue holds no windows |

## Verification
Two events can fall in the same cycle and must combine correctly: a block write from fetch and a one- or two-window pop from decode. A flush can also coincide with a write and a pop. The bench drives these together on purpose: single pops mixed with writes, which leave the head on an upper window, and flushes presented alongside a valid write. A reference queue in the bench predicts the count, the head windows and the flags after every edge, and compares them against the design.

// File: rtl/ibq_pkg.sv
package ibq_pkg;
  localparam int WIN_BYTES = 16;
  localparam int WIN_BITS  = WIN_BYTES * 8;
  localparam int WIN_OFS_W = $clog2(WIN_BYTES);
  localparam int BLK_OFS_W = WIN_OFS_W + 1;

  // Pop request encoding: 0,1,2 windows; 3 saturates to 2.
  function automatic logic [1:0] pop_sat(input logic [1:0] req);
    return (req == 2'd3) ? 2'd2 : req;
  endfunction
endpackage

// File: rtl/ibq_bank.sv
module ibq_bank #(
  parameter int ROWS  = 8,
  parameter int ENT_W = 156,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ROW_W-1:0] waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic [ROW_W-1:0] raddr,
  output logic [ENT_W-1:0] rdata
);
  logic [ENT_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ibq_ctrl.sv
module ibq_ctrl
  import ibq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int ROW_W = PTR_W - 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             fill_valid,
  input  logic [1:0]       pop_req,
  output logic             fill_ready,
  output logic             wr_en,
  output logic [ROW_W-1:0] wr_row,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count
);
  logic [1:0] req;
  logic [1:0] pops;

  assign fill_ready = (count <= CNT_W'(DEPTH - 2));
  assign wr_en      = fill_valid && fill_ready && !flush;
  assign req        = pop_sat(pop_req);

  always_comb begin
    if (flush)                       pops = 2'd0;
    else if (CNT_W'(req) > count)    pops = count[1:0];
    else                             pops = req;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      count  <= '0;
      rd_ptr <= '0;
      wr_row <= '0;
    end else begin
      count  <= count + (wr_en ? CNT_W'(2) : CNT_W'(0)) - CNT_W'(pops);
      rd_ptr <= rd_ptr + PTR_W'(pops);
      if (wr_en) wr_row <= wr_row + ROW_W'(1);
    end
  end
endmodule

// File: rtl/ibq_top.sv
module ibq_top
  import ibq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int ROW_W = PTR_W - 1,
  localparam int ROWS  = DEPTH / 2,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int TAG_W = ADDR_W - WIN_OFS_W,
  localparam int ENT_W = TAG_W + WIN_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                fill_valid,
  input  logic [ADDR_W-1:0]   fill_addr,
  input  logic [2*WIN_BITS-1:0] fill_data,
  output logic                fill_ready,
  input  logic [1:0]          pop_req,
  output logic                win0_valid,
  output logic [ADDR_W-1:0]   win0_addr,
  output logic [WIN_BITS-1:0] win0_data,
  output logic                win1_valid,
  output logic [ADDR_W-1:0]   win1_addr,
  output logic [WIN_BITS-1:0] win1_data,
  output logic [CNT_W-1:0]    occ_count,
  output logic                is_full,
  output logic                is_empty
);
  logic             wr_en;
  logic [ROW_W-1:0] wr_row;
  logic [PTR_W-1:0] rd_ptr;
  logic [ROW_W-1:0] head_row;
  logic             head_odd;
  logic [ENT_W-1:0] bank_wdata [2];
  logic [ROW_W-1:0] bank_raddr [2];
  logic [ENT_W-1:0] bank_rdata [2];
  logic [ENT_W-1:0] ent0, ent1;

  ibq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .fill_valid(fill_valid),
    .pop_req(pop_req), .fill_ready(fill_ready), .wr_en(wr_en),
    .wr_row(wr_row), .rd_ptr(rd_ptr), .count(occ_count)
  );

  // Bank 0 holds lower halves, bank 1 upper halves of each block.
  assign head_row = rd_ptr[PTR_W-1:1];
  assign head_odd = rd_ptr[0];

  for (genvar g = 0; g < 2; g++) begin : g_bank
    assign bank_wdata[g] = {fill_addr[ADDR_W-1:BLK_OFS_W], 1'(g),
                            fill_data[g*WIN_BITS +: WIN_BITS]};
    if (g == 0) begin : g_lo
      assign bank_raddr[g] = head_odd ? head_row + ROW_W'(1) : head_row;
    end else begin : g_hi
      assign bank_raddr[g] = head_row;
    end
    ibq_bank #(.ROWS(ROWS), .ENT_W(ENT_W)) u_bank (
      .clk(clk), .we(wr_en), .waddr(wr_row), .wdata(bank_wdata[g]),
      .raddr(bank_raddr[g]), .rdata(bank_rdata[g])
    );
  end

  assign ent0 = head_odd ? bank_rdata[1] : bank_rdata[0];
  assign ent1 = head_odd ? bank_rdata[0] : bank_rdata[1];

  assign win0_addr  = {ent0[ENT_W-1:WIN_BITS], {WIN_OFS_W{1'b0}}};
  assign win0_data  = ent0[WIN_BITS-1:0];
  assign win1_addr  = {ent1[ENT_W-1:WIN_BITS], {WIN_OFS_W{1'b0}}};
  assign win1_data  = ent1[WIN_BITS-1:0];
  assign win0_valid = (occ_count >= CNT_W'(1));
  assign win1_valid = (occ_count >= CNT_W'(2));
  assign is_full    = (occ_count == CNT_W'(DEPTH));
  assign is_empty   = (occ_count == '0);
endmodule

// File: rtl/ibq_sva.sv
module ibq_sva #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic              fill_valid,
  input logic              fill_ready,
  input logic [1:0]        pop_req,
  input logic              win0_valid,
  input logic [ADDR_W-1:0] win0_addr,
  input logic              win1_valid,
  input logic [ADDR_W-1:0] win1_addr,
  input logic [CNT_W-1:0]  occ_count,
  input logic              is_full,
  input logic              is_empty
);
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    occ_count <= CNT_W'(DEPTH)); // R9
  AST_NO_WRITE_UNREADY: assert property (@(posedge clk) disable iff (rst)
    fill_valid && !fill_ready && pop_req == 2'd0 && !flush
    |=> occ_count == $past(occ_count)); // R3
  AST_WRITE_ADDS_TWO: assert property (@(posedge clk) disable iff (rst)
    fill_valid && fill_ready && pop_req == 2'd0 && !flush
    |=> occ_count == $past(occ_count) + CNT_W'(2)); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> is_empty && !win0_valid); // R7
  AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (rst)
    win0_valid && win1_valid && !win0_addr[4]
    |-> win1_addr == win0_addr + ADDR_W'(16)); // R4
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    is_full |-> !fill_ready); // R3
  AST_EMPTY_NOWIN: assert property (@(posedge clk) disable iff (rst)
    is_empty |-> !win0_valid && !win1_valid); // R8
  AST_POP_CLAMP: assert property (@(posedge clk) disable iff (rst)
    !flush && !fill_valid && pop_req != 2'd0 && occ_count == CNT_W'(1)
    |=> is_empty); // R5
endmodule

bind ibq_top ibq_sva #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst(rst), .flush(flush), .fill_valid(fill_valid),
  .fill_ready(fill_ready), .pop_req(pop_req), .win0_valid(win0_valid),
  .win0_addr(win0_addr), .win1_valid(win1_valid), .win1_addr(win1_addr),
  .occ_count(occ_count), .is_full(is_full), .is_empty(is_empty)
);

// File: tb/ibq_top_test.sv
module ibq_top_test;
  localparam int DEPTH = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         flush = 1'b0;
  logic         fill_valid = 1'b0;
  logic [31:0]  fill_addr = '0;
  logic [255:0] fill_data = '0;
  logic         fill_ready;
  logic [1:0]   pop_req = 2'd0;
  logic         win0_valid, win1_valid;
  logic [31:0]  win0_addr, win1_addr;
  logic [127:0] win0_data, win1_data;
  logic [4:0]   occ_count;
  logic         is_full, is_empty;

  int checks = 0;
  int failures = 0;
  logic [31:0]  q_addr [$];
  logic [127:0] q_data [$];

  always #4 clk = ~clk;

  ibq_top uut (
    .clk(clk), .rst(rst), .flush(flush), .fill_valid(fill_valid),
    .fill_addr(fill_addr), .fill_data(fill_data), .fill_ready(fill_ready),
    .pop_req(pop_req), .win0_valid(win0_valid), .win0_addr(win0_addr),
    .win0_data(win0_data), .win1_valid(win1_valid), .win1_addr(win1_addr),
    .win1_data(win1_data), .occ_count(occ_count), .is_full(is_full),
    .is_empty(is_empty)
  );

  function automatic logic [255:0] mk_data(input logic [31:0] a);
    logic [255:0] d;
    for (int i = 0; i < 8; i++) d[i*32 +: 32] = a ^ (32'h9E37_79B9 * (i + 1));
    return d;
  endfunction

  // Compare every output to the reference queue.
  task automatic check_state(input string tag);
    int n = q_addr.size();
    bit ok = 1'b1;
    logic [31:0] e0a = (n >= 1) ? q_addr[0] : 32'h0;
    checks++;
    if (occ_count != 5'(n) || is_empty != (n == 0) || is_full != (n == DEPTH) ||
        fill_ready != (n <= DEPTH - 2) || win0_valid != (n >= 1) ||
        win1_valid != (n >= 2)) ok = 1'b0;
    if (n >= 1 && (win0_addr != q_addr[0] || win0_data != q_data[0])) ok = 1'b0;
    if (n >= 2 && (win1_addr != q_addr[1] || win1_data != q_data[1])) ok = 1'b0;
    if (!ok) begin
      failures++;
      $display("FAIL %s: count=%0d ready=%0b head=%h exp count=%0d ready=%0b head=%h",
               tag, occ_count, fill_ready, win0_addr, n, (n <= DEPTH - 2), e0a);
    end
  endtask

  // One clock: drive at negedge, update the reference, sample at next negedge.
  task automatic cycle(input bit v, input logic [31:0] a, input logic [1:0] p,
                       input bit fl);
    int n = q_addr.size();
    int pops;
    bit rdy = (n <= DEPTH - 2);
    logic [255:0] d = mk_data(a);
    fill_valid = v; fill_addr = a; fill_data = d; pop_req = p; flush = fl;
    if (fl) begin
      q_addr.delete(); q_data.delete();
    end else begin
      pops = (p == 2'd3) ? 2 : int'(p);
      if (pops > n) pops = n;
      for (int i = 0; i < pops; i++) begin
        void'(q_addr.pop_front()); void'(q_data.pop_front());
      end
      if (v && rdy) begin
        q_addr.push_back({a[31:5], 5'h00}); q_data.push_back(d[127:0]);
        q_addr.push_back({a[31:5], 5'h10}); q_data.push_back(d[255:128]);
      end
    end
    @(negedge clk);
    fill_valid = 1'b0; pop_req = 2'd0; flush = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    q_addr.delete(); q_data.delete();
    @(negedge clk);
    check_state("R1 reset state");
  endtask

  task automatic t_single;
    cycle(1, 32'h1234_5677, 2'd0, 0);
    check_state("R2 block split, low address bits ignored");
    cycle(0, 0, 2'd1, 0);
    check_state("R4 upper half after lower");
    cycle(0, 0, 2'd1, 0);
    check_state("R8 empty after draining");
  endtask

  task automatic t_fill;
    for (int i = 0; i < 8; i++) begin
      cycle(1, 32'h0000_1000 + 32'(i) * 32, 2'd0, 0);
      check_state("R9 count while filling");
    end
    check_state("R8 full at 16");
    cycle(1, 32'hDEAD_0000, 2'd0, 0);
    check_state("R3 write ignored when full");
    cycle(0, 0, 2'd1, 0);
    check_state("R3 ready low at 15");
    cycle(1, 32'hBEEF_0020, 2'd0, 0);
    check_state("R3 write ignored at 15");
    cycle(0, 0, 2'd2, 0);
    check_state("R5 pop two");
    cycle(1, 32'h0000_2000, 2'd0, 0);
    check_state("R3 write accepted at 13");
  endtask

  task automatic t_pops;
    cycle(0, 0, 2'd3, 0);
    check_state("R5 pop code 3 acts as 2");
    while (q_addr.size() > 1) begin
      cycle(0, 0, 2'd2, 0);
      check_state("R4 draining pairs from odd head");
    end
    cycle(0, 0, 2'd2, 0);
    check_state("R5 pop beyond count clamped");
  endtask

  task automatic t_concurrent;
    cycle(1, 32'h0004_0000, 2'd1, 0);
    check_state("R6 write with pop on empty");
    for (int i = 1; i < 6; i++) begin
      cycle(1, 32'h0004_0000 + 32'(i) * 32, 2'd1, 0);
      check_state("R6 write plus one pop");
    end
    for (int i = 6; i < 12; i++) begin
      cycle(1, 32'h0004_0000 + 32'(i) * 32, 2'd2, 0);
      check_state("R6 write plus two pops");
    end
  endtask

  task automatic t_flush;
    cycle(1, 32'h0008_0000, 2'd0, 0);
    cycle(1, 32'h0008_0040, 2'd2, 1);
    check_state("R7 flush drops write and pop");
    cycle(1, 32'h0009_0060, 2'd0, 0);
    check_state("R7 write after flush");
    cycle(0, 0, 2'd0, 1);
    check_state("R7 flush empties");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_single();
    t_fill();
    t_pops();
    t_concurrent();
    t_flush();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule